// File: doc/BRIEF.md
# Indexed Block Register Slave (two-wire serial bus)

This block is a slave on a two-wire serial bus of the SMBus/I2C kind. It holds a small bank of 8-bit configuration registers and presents them to the rest of the chip as one parallel vector. A bus master loads or inspects the bank only through indexed block transfers. To write, the master sends a starting register index, then a byte count, then that many data bytes. To read, the master first writes the index. It then issues a repeated start with the read address, and the slave answers with a byte count followed by register contents.

SCL and SDA are sampled in the system clock domain through a short synchroniser. Start and stop conditions are recognised from SDA edges while SCL is high. The slave drives SDA only as an open-drain pull-down (`sda_oe` = 1 pulls the line low), and it changes that drive only while SCL is low. A shared register pointer selects the register for each data byte. It advances after every byte, wraps around the bank, and keeps its value across repeated starts and stops. The byte count that a read returns comes from a count register. That register holds 8 after reset and takes the value of every byte count that a write accepts.

Top module: `smb_blkreg_slave`

## Requirements
- R1: The slave acknowledges only address byte DCh (write) and DDh (read), i.e. 7-bit address 6Eh with the direction bit as bit 0. Any other address byte, and every byte after it until the next start, is left unacknowledged.
- R2: In a write, the slave acknowledges the index byte and a non-zero count byte N, then acknowledges N data bytes. It stores them into consecutive registers starting at the index.
- R3: A write byte count of 00h is not acknowledged, and no register changes.
- R4: After DDh is acknowledged, the slave sends the byte count MSB first. After each master acknowledge it sends the next register, starting at the stored index.
- R5: After reset, a read returns the byte count 08h.
- R6: Every accepted non-zero write count becomes the byte count that later reads return.
- R7: When the master does not acknowledge a byte the slave sent, the slave releases SDA. It stays silent until the next start condition.
- R8: The register pointer wraps from the last register (index 7) to register 0, for both writes and reads. Only the low three index bits select a register.
- R9: The stored pointer survives a stop and a repeated start. A repeated start in the middle of a byte discards the partial bits and restarts address reception.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: Write data bytes beyond the count N are not acknowledged and are discarded.
- R12: After reset, every register reads 00h and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release SDA |
| bank_o | output | NUM_REGS*8 | Register bank, register i in bits [8i+7:8i] |

## Verification
The bench builds the block with its default parameters: eight registers, device address 6Eh, a reset count of 8 and two synchroniser stages. With only eight registers, a four-byte burst that starts at index 6 or 7 crosses the wrap point, so both write and read wrap-around fall inside short transfers. Because the reset count is 8 and accepted write counts of 3, 1 and 4 overwrite it, the bench can tell the reset value apart from a value loaded by a write. With two synchroniser stages, a bus half period of ten system clocks leaves slack between a drive change and the next SCL edge, so any SDA change outside SCL low would show.

// File: rtl/smb_pkg.sv
// Shared definitions for the indexed block register slave.
// Assumes the serial bus moves 8-bit bytes, MSB first.
package smb_pkg;

    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W + 1);

    // Protocol phases of the transfer engine
    typedef enum logic [3:0] {
        ST_IDLE,    // waiting for a start condition
        ST_ADDR,    // receiving the address byte
        ST_OFFS,    // receiving the register index
        ST_CNT,     // receiving the write byte count
        ST_WDATA,   // receiving write data
        ST_ACK,     // slave drives the acknowledge bit
        ST_TX,      // slave shifts a byte out
        ST_MACK,    // master acknowledge slot after a sent byte
        ST_IGNORE   // not addressed / aborted, silent until start or stop
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA into the system clock domain and derives bus events.
// Assumes each SCL phase lasts several system clocks; no glitch filtering.
// Both lines pass through chains of equal length, so their relative order is kept.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;

    // Synchroniser chains plus one history stage; idle bus level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[STAGES-2:0], sda_in};
            scl_q     <= scl_chain[STAGES-1];
            sda_q     <= sda_chain[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised lines
    always_comb begin
        scl_s     = scl_chain[STAGES-1];
        sda_s     = sda_chain[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/smb_reg_bank.sv
// Register storage: NUM_REGS byte registers plus the read byte-count register.
// Assumes at most one write per cycle; the read port is combinational.
module smb_reg_bank
    import smb_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int COUNT_RESET = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_idx,
    output logic [BYTE_W-1:0]           rd_data,
    input  logic                        cnt_we,
    input  logic [BYTE_W-1:0]           cnt_data,
    output logic [BYTE_W-1:0]           rd_count,
    output logic [NUM_REGS*BYTE_W-1:0]  bank_o
);

    localparam int IDX_W = $clog2(NUM_REGS);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [BYTE_W-1:0] q;

        // One configuration register, loaded when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                q <= wr_data;
        end

        assign bank_o[i*BYTE_W +: BYTE_W] = q;
    end

    // Read byte-count register, loaded from accepted write counts
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_count <= BYTE_W'(COUNT_RESET);
        else if (cnt_we)
            rd_count <= cnt_data;
    end

    // Read multiplexer for the transmit path
    always_comb begin
        rd_data = bank_o[rd_idx*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/smb_xfer_fsm.sv
// Transfer engine: decodes address, index, count and data bytes, and drives
// acknowledge and read data onto SDA through an open-drain enable.
// Assumes the synchronised events from smb_line_sync. It changes sda_oe only
// on an SCL falling edge, or releases it on a start or stop.
module smb_xfer_fsm
    import smb_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter logic [6:0] DEV_ADDR = 7'h6E
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_rise,
    input  logic                        scl_fall,
    input  logic                        sda_s,
    input  logic                        start_det,
    input  logic                        stop_det,
    input  logic [BYTE_W-1:0]           rd_data,
    input  logic [BYTE_W-1:0]           rd_count,
    output logic                        sda_oe,
    output logic                        wr_en,
    output logic [$clog2(NUM_REGS)-1:0] wr_idx,
    output logic [BYTE_W-1:0]           wr_data,
    output logic                        cnt_we,
    output logic [BYTE_W-1:0]           cnt_data,
    output logic [$clog2(NUM_REGS)-1:0] rd_idx,
    output smb_state_e                  state_o
);

    localparam int                IDX_W   = $clog2(NUM_REGS);
    localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
    localparam logic [BYTE_W-1:0] ADDR_RD = {DEV_ADDR, 1'b1};
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W);

    smb_state_e        state;
    smb_state_e        after_ack;
    smb_state_e        ack_next;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] remain;
    logic [BCNT_W-1:0] bcnt;
    logic [IDX_W-1:0]  ptr;
    logic              mack_ok;
    logic              byte_ok;
    logic              rx_state;

    // Judge a completed received byte: acknowledge or not, and the phase after it
    always_comb begin
        byte_ok  = 1'b0;
        ack_next = ST_IDLE;
        rx_state = 1'b0;
        case (state)
            ST_ADDR: begin
                rx_state = 1'b1;
                byte_ok  = (shreg == ADDR_WR) || (shreg == ADDR_RD);
                ack_next = shreg[0] ? ST_TX : ST_OFFS;
            end
            ST_OFFS: begin
                rx_state = 1'b1;
                byte_ok  = 1'b1;
                ack_next = ST_CNT;
            end
            ST_CNT: begin
                rx_state = 1'b1;
                byte_ok  = (shreg != '0);
                ack_next = ST_WDATA;
            end
            ST_WDATA: begin
                rx_state = 1'b1;
                byte_ok  = (remain != '0);
                ack_next = ST_WDATA;
            end
            default: ;
        endcase
    end

    // Protocol sequencing, bit shifting and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            shreg     <= '0;
            tx_sh     <= '0;
            remain    <= '0;
            bcnt      <= '0;
            ptr       <= '0;
            mack_ok   <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            cnt_we    <= 1'b0;
            cnt_data  <= '0;
        end else begin
            wr_en  <= 1'b0;
            cnt_we <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise) begin
                    shreg <= {shreg[BYTE_W-2:0], sda_s};
                    bcnt  <= bcnt + 1'b1;
                end else if (scl_fall && (bcnt == LAST_BIT)) begin
                    bcnt <= '0;
                    if (byte_ok) begin
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ack_next;
                        case (state)
                            ST_OFFS: ptr <= shreg[IDX_W-1:0];
                            ST_CNT: begin
                                remain   <= shreg;
                                cnt_we   <= 1'b1;
                                cnt_data <= shreg;
                            end
                            ST_WDATA: begin
                                wr_en   <= 1'b1;
                                wr_idx  <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                                remain  <= remain - 1'b1;
                            end
                            default: ;
                        endcase
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
            end else begin
                case (state)
                    ST_ACK: begin
                        if (scl_fall) begin
                            bcnt <= '0;
                            if (after_ack == ST_TX) begin
                                tx_sh  <= rd_count;
                                sda_oe <= ~rd_count[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= after_ack;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bcnt <= bcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                bcnt   <= '0;
                                state  <= ST_MACK;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                ptr    <= ptr + 1'b1;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_idx  = ptr;
    assign state_o = state;

endmodule

// File: rtl/smb_blkreg_slave.sv
// Top level of the indexed block register slave. It ties the line
// synchroniser, the transfer engine and the register bank together.
// Assumes NUM_REGS is a power of two, so the pointer wraps naturally.
module smb_blkreg_slave
    import smb_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h6E,
    parameter int         COUNT_RESET = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] bank_o
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_data;
    logic              cnt_we;
    logic [BYTE_W-1:0] cnt_data;
    logic [BYTE_W-1:0] rd_count;
    smb_state_e        fsm_state;

    smb_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_xfer_fsm #(
        .NUM_REGS (NUM_REGS),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_count  (rd_count),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .cnt_we    (cnt_we),
        .cnt_data  (cnt_data),
        .rd_idx    (rd_idx),
        .state_o   (fsm_state)
    );

    smb_reg_bank #(
        .NUM_REGS    (NUM_REGS),
        .COUNT_RESET (COUNT_RESET)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cnt_we   (cnt_we),
        .cnt_data (cnt_data),
        .rd_count (rd_count),
        .bank_o   (bank_o)
    );

endmodule

// File: rtl/smb_blkreg_checker.sv
// Protocol checker bound into smb_blkreg_slave.
// It watches the synchronised SCL, the SDA drive, the engine phase and the
// register bank.
module smb_blkreg_checker
    import smb_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int COUNT_RESET = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_s,
    input logic                       sda_oe,
    input smb_state_e                 state,
    input logic                       wr_en,
    input logic                       cnt_we,
    input logic [BYTE_W-1:0]          rd_count,
    input logic [NUM_REGS*BYTE_W-1:0] bank_o
);

    logic [NUM_REGS*BYTE_W-1:0] bank_prev;
    logic [NUM_REGS-1:0]        chg;
    logic                       cnt_seen;

    // History of the bank and of count-register loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_prev <= '0;
            cnt_seen  <= 1'b0;
        end else begin
            bank_prev <= bank_o;
            if (cnt_we)
                cnt_seen <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chg
        assign chg[i] = (bank_o[i*BYTE_W +: BYTE_W] != bank_prev[i*BYTE_W +: BYTE_W]);
    end

    // R10: the pull-down is applied only while SCL is low
    a_r10_pull_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R2: at most one register changes per cycle
    a_r2_one_reg_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg));

    // R3: a register changes only after an accepted data byte
    a_r3_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |-> $past(wr_en));

    // R5: until a count is accepted, the read count keeps its reset value
    a_r5_count_default: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_seen |-> (rd_count == BYTE_W'(COUNT_RESET)));

    // R7: SDA is released whenever the engine is idle or ignoring the bus
    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) || (state == ST_IGNORE)) |-> !sda_oe);

endmodule

bind smb_blkreg_slave smb_blkreg_checker #(
    .NUM_REGS    (NUM_REGS),
    .COUNT_RESET (COUNT_RESET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .state    (fsm_state),
    .wr_en    (wr_en),
    .cnt_we   (cnt_we),
    .rd_count (rd_count),
    .bank_o   (bank_o)
);

// File: tb/smb_blkreg_slave_test.sv
`timescale 1ns/1ps
// Bench for smb_blkreg_slave. A behavioural master drives the bus and a model
// of the bank, count and pointer predicts every answer. The model bank is
// compared with bank_o on every idle clock.
module smb_blkreg_slave_test;

    localparam int NREG = 8;
    localparam int Q    = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_bus;
    logic              sda_oe;
    logic [NREG*8-1:0] bank_o;

    int          errors = 0;
    int          checks = 0;
    logic [7:0]  model [NREG];
    int          model_cnt = 8;
    int          model_ptr = 0;
    bit          busy = 1'b1;
    bit          done = 1'b0;
    logic        oe_prev = 1'b0;
    logic [7:0]  wq [$];

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    smb_blkreg_slave #(
        .NUM_REGS    (NREG),
        .DEV_ADDR    (7'h6E),
        .COUNT_RESET (8),
        .SYNC_STAGES (2)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl),
        .sda_in (sda_bus),
        .sda_oe (sda_oe),
        .bank_o (bank_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_vec();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Model bank compared on every clock while the bus is idle (R2, R3, R11)
    always @(negedge clk) begin
        if (rst_n && !busy)
            check(bank_o == model_vec(), "R2", "idle bank compare", bank_o, model_vec());
    end

    // SDA drive may only move while SCL is low (R10)
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev))
            check(scl == 1'b0, "R10", "sda_oe change with SCL", scl, 0);
        oe_prev = sda_oe;
    end

    task automatic bus_start();
        busy = 1'b1;
        sda_m = 1'b0; wt(Q);
        scl = 1'b0; wt(2);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q);
        scl = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
        busy = 1'b0; wt(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; wt(Q);
        scl = 1'b1; wt(Q/2);
        s = sda_bus; wt(Q/2);
        scl = 1'b0; wt(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    // After DDh: count byte then nread data bytes, last one not acknowledged
    task automatic read_tail(input int nread, input string ctag, input string dtag);
        logic ack;
        logic [7:0] b;
        send_byte(8'hDD, ack);
        check(ack == 1'b1, "R1", "read address ack", ack, 1);
        recv_byte(nread > 0, b);
        check(b == model_cnt[7:0], ctag, "byte count", b, model_cnt);
        for (int k = 0; k < nread; k++) begin
            recv_byte(k < nread - 1, b);
            check(b == model[model_ptr], dtag, "read data", b, model[model_ptr]);
            model_ptr = (model_ptr + 1) % NREG;
        end
        wt(4);
        check(sda_oe == 1'b0, "R7", "released after master nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] off, input int nread,
                           input string ctag, input string dtag);
        logic ack;
        bus_start();
        send_byte(8'hDC, ack);
        check(ack == 1'b1, "R1", "write address ack", ack, 1);
        send_byte(off, ack);
        check(ack == 1'b1, "R2", "index ack", ack, 1);
        model_ptr = off % NREG;
        bus_rstart();
        read_tail(nread, ctag, dtag);
    endtask

    // Block write with the bytes in wq; bytes past cnt expect no ack
    task automatic do_write(input logic [7:0] off, input logic [7:0] cnt, input string tag);
        logic ack;
        bit   exp;
        bus_start();
        send_byte(8'hDC, ack);
        check(ack == 1'b1, "R1", "write address ack", ack, 1);
        send_byte(off, ack);
        check(ack == 1'b1, "R2", "index ack", ack, 1);
        model_ptr = off % NREG;
        send_byte(cnt, ack);
        exp = (cnt != 8'h00);
        check(ack == exp, exp ? "R2" : "R3", "count ack", ack, exp);
        if (exp) begin
            model_cnt = cnt;
            foreach (wq[i]) begin
                send_byte(wq[i], ack);
                exp = (i < cnt);
                check(ack == exp, exp ? tag : "R11", "data ack", ack, exp);
                if (exp) begin
                    model[model_ptr] = wq[i];
                    model_ptr = (model_ptr + 1) % NREG;
                end
                if (!ack) break;
            end
        end
        bus_stop();
        check(bank_o == model_vec(), tag, "bank after write", bank_o, model_vec());
    endtask

    initial begin
        logic ack;
        logic s;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R12: reset state
        check(bank_o == '0, "R12", "bank after reset", bank_o, 0);
        check(sda_oe == 1'b0, "R12", "sda released after reset", sda_oe, 0);
        busy = 1'b0;

        // R5: first read returns the reset count
        do_read(8'h00, 2, "R5", "R4");

        // R2 and R6: write three bytes at index 2, then read them back
        wq = '{8'hA1, 8'hB2, 8'hC3};
        do_write(8'h02, 8'h03, "R2");
        do_read(8'h02, 3, "R6", "R4");

        // R1: foreign addresses are ignored, including following bytes
        bus_start();
        send_byte(8'hA0, ack);
        check(ack == 1'b0, "R1", "foreign address nack", ack, 0);
        send_byte(8'h55, ack);
        check(ack == 1'b0, "R1", "byte after foreign address", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hDE, ack);
        check(ack == 1'b0, "R1", "address DE nack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h6E, ack);
        check(ack == 1'b0, "R1", "unshifted address nack", ack, 0);
        bus_stop();

        // R3: zero count rejected, bank unchanged
        wq = '{8'hEE};
        do_write(8'h01, 8'h00, "R3");

        // R11: single-byte write followed by one extra byte
        wq = '{8'h5A, 8'h77};
        do_write(8'h05, 8'h01, "R2");

        // R8: write and read across the wrap point
        wq = '{8'h11, 8'h22, 8'h33, 8'h44};
        do_write(8'h06, 8'h04, "R8");
        do_read(8'h07, 4, "R6", "R8");
        do_read(8'h0F, 1, "R6", "R8");

        // R7: master refuses the count byte, slave stays silent on the next byte
        bus_start();
        send_byte(8'hDC, ack);
        send_byte(8'h00, ack);
        model_ptr = 0;
        bus_rstart();
        send_byte(8'hDD, ack);
        check(ack == 1'b1, "R1", "read address ack", ack, 1);
        recv_byte(1'b0, b);
        check(b == model_cnt[7:0], "R7", "count before abort", b, model_cnt);
        recv_byte(1'b0, b);
        check(b == 8'hFF, "R7", "silent after nack", b, 8'hFF);
        check(sda_oe == 1'b0, "R7", "sda released before stop", sda_oe, 0);
        bus_stop();

        // R9: index survives a stop
        bus_start();
        send_byte(8'hDC, ack);
        send_byte(8'h03, ack);
        check(ack == 1'b1, "R9", "index ack", ack, 1);
        model_ptr = 3;
        bus_stop();
        bus_start();
        read_tail(1, "R9", "R9");

        // R9: repeated start after three bits of a byte keeps the pointer
        bus_start();
        send_byte(8'hDC, ack);
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        bus_rstart();
        read_tail(2, "R9", "R9");

        wt(20);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule